// File: doc/BRIEF.md
# SPI Register Slave with Burst Access

This block lets a microcontroller reach a 64-entry by 8-bit register file over a four-wire SPI link in mode 0. The link runs at up to 2 MHz. The block works on its own system clock and samples the select, clock and data lines through synchronisers. Every transaction opens with a command byte, sent MSB first:

- bit 7 is the direction (1 = write, 0 = read);
- bit 6 enables address increment;
- bits 5:0 are the start address.

Any number of data bytes follow the command byte. With increment set, each byte moves to the next address, so one select period can cover a multi-byte register laid out least significant byte first at the lowest address.

On the chip side, a write port lets other logic update any register, including the read-only ones that software cannot change. A read port observes any register. A one-cycle read strobe marks every byte actually delivered to the master, so that status registers which clear on read can be cleared by the surrounding logic.

A controller with four states drives the serial side:

- IDLE: select is high.
- CMD: the command byte is being shifted in.
- WDATA: write data is being received.
- RDATA: read data is being sent.

Its transitions are:

- start: IDLE to CMD when select falls.
- write-decode: CMD to WDATA after a command byte with the direction bit set.
- read-decode: CMD to RDATA after a command byte with the direction bit clear.
- abort: any state to IDLE when select rises.

The timing assumptions are as follows. Each SCK phase lasts at least 6 system clocks. The first SCK rising edge comes at least 3 system clocks after select falls.

Top module: `spi_regslave`

## Requirements
- R1: The command byte is taken MSB first on SCK rising edges. Bit 7 = 1 selects a write and 0 a read, bit 6 is the increment flag, and bits 5:0 are the start address.
- R2: Each complete write data byte is stored at the current address and is visible on the internal read port afterwards.
- R3: With the increment flag set, the address advances by one after every data byte and wraps from 63 to 0. With it clear, every byte uses the start address.
- R4: SPI writes to read-only addresses are ignored. By default the read-only addresses are 0 and 32.
- R5: In a read, each byte is taken from the current address and presented MSB first on MISO. The bit changes only after SCK falling edges, so the master samples it on the rising edges.
- R6: The MISO output enable is low whenever select is high and high whenever select is low.
- R7: Raising select ends the transaction. A partial byte is discarded with no register write, and the next transaction starts again with a command byte.
- R8: `rd_stb` pulses for one clock, with `rd_addr`, when the eighth bit of a read data byte has been clocked. There is no strobe for write bytes or for a read byte cut short by select.
- R9: The byte that follows a strobe is loaded two clocks after the strobe. A clear written on the internal port in the clock after the strobe is therefore seen by the next byte of the same transaction.
- R10: After reset all registers read 0. The internal write port can write any address, read-only ones included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_ss_n | input | 1 | Select, active low |
| spi_sck | input | 1 | Serial clock, idles low |
| spi_mosi | input | 1 | Serial data from master |
| spi_miso | output | 1 | Serial data to master |
| spi_miso_oe | output | 1 | MISO driver enable for the pad |
| hw_we | input | 1 | Internal write enable |
| hw_waddr | input | 6 | Internal write address |
| hw_wdata | input | 8 | Internal write data |
| hw_raddr | input | 6 | Internal read address |
| hw_rdata | output | 8 | Internal read data |
| rd_stb | output | 1 | Pulse per byte delivered to the master |
| rd_addr | output | 6 | Address of the delivered byte |

## Verification
The bench goes after these corner cases:

- Address wrap during an incrementing burst that also crosses a read-only address. A design that stops at 63 or writes the protected word would corrupt addresses 0 or 63.
- A repeated non-incrementing read of a clear-on-read register. A design that prefetches the next byte too early returns the stale value twice.
- Aborts in the middle of a byte, both in a command byte and in write and read data bytes. A design that keeps the bit count would misalign the next command, store a partial byte, or fire a spurious strobe.
- The first read bit after the command byte. A design that shifts on that falling edge drops the MSB.

// File: rtl/spi_regslave_pkg.sv
package spi_regslave_pkg;

    // Serial-side controller states
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CMD   = 2'd1,
        ST_WDATA = 2'd2,
        ST_RDATA = 2'd3
    } spi_state_e;

    // Clocks between a read strobe and the load of the following byte
    localparam int LOAD_DELAY = 2;

endpackage

// File: rtl/spi_rs_sync.sv
module spi_rs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ss_n,
    input  logic sck,
    input  logic mosi,
    output logic ss_act,
    output logic sck_rise,
    output logic sck_fall,
    output logic mosi_s
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] ss_q;
    logic [STAGES-1:0] sck_q;
    logic [STAGES-1:0] mosi_q;
    logic              sck_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ss_q   <= '1;
            sck_q  <= '0;
            mosi_q <= '0;
            sck_d  <= 1'b0;
        end else begin
            ss_q   <= {ss_q[STAGES-2:0], ss_n};
            sck_q  <= {sck_q[STAGES-2:0], sck};
            mosi_q <= {mosi_q[STAGES-2:0], mosi};
            sck_d  <= sck_q[TOP];
        end
    end

    always_comb begin
        ss_act   = ~ss_q[TOP];
        sck_rise = sck_q[TOP] & ~sck_d;
        sck_fall = ~sck_q[TOP] & sck_d;
        mosi_s   = mosi_q[TOP];
    end

endmodule

// File: rtl/spi_rs_regfile.sv
module spi_rs_regfile #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter logic [(1<<ADDR_W)-1:0] RO_MASK = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_we,
    input  logic [ADDR_W-1:0] spi_addr,
    input  logic [DATA_W-1:0] spi_wdata,
    output logic [DATA_W-1:0] spi_rdata,
    input  logic              hw_we,
    input  logic [ADDR_W-1:0] hw_waddr,
    input  logic [DATA_W-1:0] hw_wdata,
    input  logic [ADDR_W-1:0] hw_raddr,
    output logic [DATA_W-1:0] hw_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (spi_we && (spi_addr == ADDR_W'(i)) && !RO_MASK[i])
                    mem[i] <= spi_wdata;
                else if (hw_we && (hw_waddr == ADDR_W'(i)))
                    mem[i] <= hw_wdata;
            end
        end
    end

    always_comb begin
        spi_rdata = mem[spi_addr];
        hw_rdata  = mem[hw_raddr];
    end

endmodule

// File: rtl/spi_rs_fsm.sv
module spi_rs_fsm
    import spi_regslave_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ss_act,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              mosi_s,
    input  logic [DATA_W-1:0] rf_rdata,
    output logic              rf_we,
    output logic [ADDR_W-1:0] rf_addr,
    output logic [DATA_W-1:0] rf_wdata,
    output logic              miso_bit,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] rd_addr,
    output spi_state_e        state,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              inc,
    output logic              data_done
);
    localparam int DIR_BIT = DATA_W - 1;
    localparam int INC_BIT = DATA_W - 2;
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(DATA_W - 1);

    spi_state_e state_q, state_d;
    logic [CNT_W-1:0]      bit_cnt_q;
    logic [DATA_W-1:0]     rx_q, tx_q, rx_next;
    logic [ADDR_W-1:0]     addr_q, rd_addr_q;
    logic                  inc_q, rd_stb_q;
    logic [LOAD_DELAY-1:0] load_q;
    logic                  in_xfer, byte_end, start_load;

    // Shared decode of the serial side
    always_comb begin
        in_xfer    = ss_act && (state_q != ST_IDLE);
        rx_next    = {rx_q[DATA_W-2:0], mosi_s};
        byte_end   = in_xfer && sck_rise && (bit_cnt_q == LAST_BIT);
        start_load = byte_end &&
                     (((state_q == ST_CMD) && !rx_next[DIR_BIT]) ||
                      (state_q == ST_RDATA));
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (ss_act) state_d = ST_CMD;
            ST_CMD: begin
                if (!ss_act)
                    state_d = ST_IDLE;
                else if (byte_end)
                    state_d = rx_next[DIR_BIT] ? ST_WDATA : ST_RDATA;
            end
            ST_WDATA: if (!ss_act) state_d = ST_IDLE;
            ST_RDATA: if (!ss_act) state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Shift registers, bit counter, address and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt_q <= '0;
            rx_q      <= '0;
            tx_q      <= '0;
            addr_q    <= '0;
            rd_addr_q <= '0;
            inc_q     <= 1'b0;
            rd_stb_q  <= 1'b0;
            load_q    <= '0;
        end else if (!ss_act) begin
            bit_cnt_q <= '0;
            tx_q      <= '0;
            rd_stb_q  <= 1'b0;
            load_q    <= '0;
        end else begin
            rd_stb_q <= 1'b0;
            load_q   <= {load_q[LOAD_DELAY-2:0], start_load};
            if (in_xfer && sck_rise) begin
                bit_cnt_q <= bit_cnt_q + 1'b1;
                rx_q      <= rx_next;
            end
            if (load_q[LOAD_DELAY-1])
                tx_q <= rf_rdata;
            else if ((state_q == ST_RDATA) && sck_fall && (bit_cnt_q != '0))
                tx_q <= {tx_q[DATA_W-2:0], 1'b0};
            if (byte_end) begin
                unique case (state_q)
                    ST_CMD: begin
                        addr_q <= rx_next[ADDR_W-1:0];
                        inc_q  <= rx_next[INC_BIT];
                    end
                    ST_RDATA: begin
                        rd_stb_q  <= 1'b1;
                        rd_addr_q <= addr_q;
                        if (inc_q) addr_q <= addr_q + 1'b1;
                    end
                    ST_WDATA: begin
                        if (inc_q) addr_q <= addr_q + 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end

    // Outputs
    always_comb begin
        rf_we     = byte_end && (state_q == ST_WDATA);
        rf_addr   = addr_q;
        rf_wdata  = rx_next;
        miso_bit  = (state_q == ST_RDATA) ? tx_q[DATA_W-1] : 1'b0;
        rd_stb    = rd_stb_q;
        rd_addr   = rd_addr_q;
        state     = state_q;
        bit_cnt   = bit_cnt_q;
        inc       = inc_q;
        data_done = byte_end && ((state_q == ST_WDATA) || (state_q == ST_RDATA));
    end

endmodule

// File: rtl/spi_regslave.sv
module spi_regslave
    import spi_regslave_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter logic [(1<<ADDR_W)-1:0] RO_MASK = 64'h0000_0001_0000_0001
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_ss_n,
    input  logic              spi_sck,
    input  logic              spi_mosi,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              hw_we,
    input  logic [ADDR_W-1:0] hw_waddr,
    input  logic [DATA_W-1:0] hw_wdata,
    input  logic [ADDR_W-1:0] hw_raddr,
    output logic [DATA_W-1:0] hw_rdata,
    output logic              rd_stb,
    output logic [ADDR_W-1:0] rd_addr
);
    localparam int CNT_W = $clog2(DATA_W);

    logic              ss_act, sck_rise, sck_fall, mosi_s;
    logic              rf_we;
    logic [ADDR_W-1:0] rf_addr;
    logic [DATA_W-1:0] rf_wdata, rf_rdata;
    logic              miso_bit;
    spi_state_e        fsm_state;
    logic [CNT_W-1:0]  fsm_bit_cnt;
    logic              fsm_inc, fsm_data_done;

    spi_rs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ss_n     (spi_ss_n),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .ss_act   (ss_act),
        .sck_rise (sck_rise),
        .sck_fall (sck_fall),
        .mosi_s   (mosi_s)
    );

    spi_rs_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ss_act    (ss_act),
        .sck_rise  (sck_rise),
        .sck_fall  (sck_fall),
        .mosi_s    (mosi_s),
        .rf_rdata  (rf_rdata),
        .rf_we     (rf_we),
        .rf_addr   (rf_addr),
        .rf_wdata  (rf_wdata),
        .miso_bit  (miso_bit),
        .rd_stb    (rd_stb),
        .rd_addr   (rd_addr),
        .state     (fsm_state),
        .bit_cnt   (fsm_bit_cnt),
        .inc       (fsm_inc),
        .data_done (fsm_data_done)
    );

    spi_rs_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RO_MASK(RO_MASK)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .spi_we    (rf_we),
        .spi_addr  (rf_addr),
        .spi_wdata (rf_wdata),
        .spi_rdata (rf_rdata),
        .hw_we     (hw_we),
        .hw_waddr  (hw_waddr),
        .hw_wdata  (hw_wdata),
        .hw_raddr  (hw_raddr),
        .hw_rdata  (hw_rdata)
    );

    // The pad driver is enabled straight from the select pin
    always_comb begin
        spi_miso_oe = ~spi_ss_n;
        spi_miso    = miso_bit;
    end

endmodule

// File: rtl/spi_regslave_chk.sv
module spi_regslave_chk
    import spi_regslave_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_stb,
    input spi_state_e        state,
    input logic [CNT_W-1:0]  bit_cnt,
    input logic [ADDR_W-1:0] addr,
    input logic              inc,
    input logic              data_done
);
    // R8: strobe lasts one clock per delivered byte
    a_r8_stb_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    // R8: strobe only comes out of a read transfer
    a_r8_stb_in_read: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |-> (state == ST_RDATA));

    // R7: an idle controller holds no partial bits
    a_r7_idle_no_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (bit_cnt == '0));

    // R3: incrementing burst steps the address with wrap
    a_r3_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (data_done && inc) |=> (addr == ADDR_W'($past(addr) + 1'b1)));

    // R3: non-incrementing burst keeps the address
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (data_done && !inc) |=> $stable(addr));

endmodule

bind spi_regslave spi_regslave_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_stb    (rd_stb),
    .state     (fsm_state),
    .bit_cnt   (fsm_bit_cnt),
    .addr      (u_fsm.rf_addr),
    .inc       (fsm_inc),
    .data_done (fsm_data_done)
);

// File: tb/spi_regslave_test.sv
module spi_regslave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HALF = 8 * CLK_PERIOD;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_ss_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic       spi_miso, spi_miso_oe;
    logic       hw_we = 1'b0;
    logic [5:0] hw_waddr = '0, hw_raddr = '0;
    logic [7:0] hw_wdata = '0, hw_rdata;
    logic       rd_stb;
    logic [5:0] rd_addr;

    spi_regslave uut (
        .clk(clk), .rst_n(rst_n), .spi_ss_n(spi_ss_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_miso_oe(spi_miso_oe),
        .hw_we(hw_we), .hw_waddr(hw_waddr), .hw_wdata(hw_wdata),
        .hw_raddr(hw_raddr), .hw_rdata(hw_rdata), .rd_stb(rd_stb), .rd_addr(rd_addr)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit finished = 0;
    logic [7:0] ref_regs [64];
    logic [63:0] ro = 64'h0000_0001_0000_0001;
    logic [7:0] tx_buf [16];
    logic [7:0] rx_buf [16];
    logic [5:0] stb_q [$];
    bit   cmp_en = 0;
    string cmp_req = "R10";
    bit   clr_en = 0;
    logic [5:0] clr_addr = '0;
    int   req_cnt = 0, req_seen = 0;
    logic [5:0] req_addr = '0;
    logic [7:0] req_data = '0;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Reference model compared every clock during idle windows; drives the internal port
    always @(negedge clk) begin
        if (cmp_en) chk(hw_rdata === ref_regs[hw_raddr], cmp_req, hw_rdata, ref_regs[hw_raddr]);
        hw_raddr = hw_raddr + 1'b1;
        hw_we = 1'b0;
        if (rd_stb) begin
            stb_q.push_back(rd_addr);
            if (clr_en && rd_addr == clr_addr) begin
                hw_we = 1'b1; hw_waddr = rd_addr; hw_wdata = 8'h00;
                ref_regs[rd_addr] = 8'h00;
            end
        end
        if (req_cnt != req_seen) begin
            req_seen = req_cnt;
            hw_we = 1'b1; hw_waddr = req_addr; hw_wdata = req_data;
            ref_regs[req_addr] = req_data;
        end
    end

    task automatic hw_write(input logic [5:0] a, input logic [7:0] d);
        req_addr = a; req_data = d; req_cnt++;
        repeat (3) @(negedge clk);
    endtask

    task automatic idle_sweep(input string req);
        cmp_req = req; cmp_en = 1;
        repeat (66) @(negedge clk);
        cmp_en = 0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] rx);
        for (int i = 7; i >= 0; i--) begin
            spi_mosi = tx[i];
            #(HALF);
            rx[i] = spi_miso;
            spi_sck = 1'b1;
            #(HALF);
            spi_sck = 1'b0;
        end
    endtask

    task automatic spi_bits(input logic [7:0] tx, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            spi_mosi = tx[i];
            #(HALF); spi_sck = 1'b1; #(HALF); spi_sck = 1'b0;
        end
    endtask

    task automatic spi_end();
        #(HALF); spi_ss_n = 1'b1;
        repeat (6) @(negedge clk);
        chk(spi_miso_oe == 1'b0, "R6", spi_miso_oe, 0);
    endtask

    task automatic spi_xact(input logic [7:0] cmd, input int n);
        logic [7:0] dummy;
        @(negedge clk);
        spi_ss_n = 1'b0;
        #(HALF);
        chk(spi_miso_oe == 1'b1, "R6", spi_miso_oe, 1);
        spi_byte(cmd, dummy);
        for (int i = 0; i < n; i++) spi_byte(tx_buf[i], rx_buf[i]);
        spi_end();
    endtask

    task automatic model_write(input logic [7:0] cmd, input int n);
        logic [5:0] a = cmd[5:0];
        for (int i = 0; i < n; i++) begin
            if (!ro[a]) ref_regs[a] = tx_buf[i];
            if (cmd[6]) a = a + 1'b1;
        end
    endtask

    task automatic chk_stb(input string req, input int n, input logic [5:0] a0, input bit inc);
        logic [5:0] a = a0;
        chk(stb_q.size() == n, req, stb_q.size(), n);
        for (int i = 0; i < n && i < stb_q.size(); i++) begin
            chk(stb_q[i] == a, req, stb_q[i], a);
            if (inc) a = a + 1'b1;
        end
        stb_q.delete();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) ref_regs[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state, R6 idle enable, R8 no strobe
        chk(rd_stb == 1'b0, "R8", rd_stb, 0);
        chk(spi_miso_oe == 1'b0, "R6", spi_miso_oe, 0);
        idle_sweep("R10");

        // R1 R2: single write of A5 to address 5
        tx_buf[0] = 8'hA5; spi_xact(8'h85, 1); model_write(8'h85, 1);
        idle_sweep("R2");

        // R5 R8: single read of address 5
        stb_q.delete();
        spi_xact(8'h05, 1);
        chk(rx_buf[0] == 8'hA5, "R5", rx_buf[0], 8'hA5);
        chk_stb("R8", 1, 6'd5, 1'b0);

        // R3 R4: incrementing burst write from 62 wraps through read-only 0
        tx_buf[0] = 8'h11; tx_buf[1] = 8'h22; tx_buf[2] = 8'h99; tx_buf[3] = 8'h44;
        spi_xact(8'hFE, 4); model_write(8'hFE, 4);
        idle_sweep("R3");

        // R3: non-incrementing burst write to 10
        tx_buf[0] = 8'h01; tx_buf[1] = 8'h02; tx_buf[2] = 8'h03;
        spi_xact(8'h8A, 3); model_write(8'h8A, 3);
        idle_sweep("R3");

        // R3 R5 R8: incrementing burst read from 62
        stb_q.delete();
        spi_xact(8'h7E, 4);
        chk(rx_buf[0] == 8'h11, "R5", rx_buf[0], 8'h11);
        chk(rx_buf[1] == 8'h22, "R3", rx_buf[1], 8'h22);
        chk(rx_buf[2] == 8'h00, "R4", rx_buf[2], 8'h00);
        chk(rx_buf[3] == 8'h44, "R3", rx_buf[3], 8'h44);
        chk_stb("R8", 4, 6'd62, 1'b1);

        // R3: non-incrementing burst read of 10
        spi_xact(8'h0A, 2);
        chk(rx_buf[0] == 8'h03, "R3", rx_buf[0], 8'h03);
        chk(rx_buf[1] == 8'h03, "R3", rx_buf[1], 8'h03);
        chk_stb("R8", 2, 6'd10, 1'b0);

        // R4: write to read-only 32 ignored; R10: internal port writes it
        tx_buf[0] = 8'h5A; spi_xact(8'hA0, 1); model_write(8'hA0, 1);
        idle_sweep("R4");
        hw_write(6'd32, 8'h6B);
        spi_xact(8'h20, 1);
        chk(rx_buf[0] == 8'h6B, "R10", rx_buf[0], 8'h6B);
        stb_q.delete();

        // R7: abort inside a write data byte
        @(negedge clk); spi_ss_n = 1'b0; #(HALF);
        spi_byte(8'h94, rx_buf[0]); spi_bits(8'hFF, 4); spi_end();
        idle_sweep("R7");
        // R7: abort inside a command byte, then a clean write
        @(negedge clk); spi_ss_n = 1'b0; #(HALF);
        spi_bits(8'h00, 4); spi_end();
        tx_buf[0] = 8'h77; spi_xact(8'h94, 1); model_write(8'h94, 1);
        idle_sweep("R7");
        // R8: abort inside a read data byte gives no strobe
        stb_q.delete();
        @(negedge clk); spi_ss_n = 1'b0; #(HALF);
        spi_byte(8'h05, rx_buf[0]); spi_bits(8'h00, 4); spi_end();
        chk_stb("R8", 0, 6'd0, 1'b0);

        // R9: clear-on-read seen by the repeated read
        hw_write(6'd40, 8'hC3);
        clr_addr = 6'd40; clr_en = 1;
        spi_xact(8'h28, 2);
        clr_en = 0;
        chk(rx_buf[0] == 8'hC3, "R9", rx_buf[0], 8'hC3);
        chk(rx_buf[1] == 8'h00, "R9", rx_buf[1], 8'h00);
        chk_stb("R9", 2, 6'd40, 1'b0);
        idle_sweep("R9");

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule